// File: doc/BRIEF.md
# Dual-Owner Command Mailbox

This block is a shared mailbox between a host processor and an embedded controller. Each side passes 32-bit message words to the other: an 8-bit command type in the upper byte and a 24-bit payload below it. The host reaches the mailbox through a small register port. The controller has a set of strobe inputs. With these it claims or releases the mailbox, posts an outbound word, and acknowledges an inbound word it has taken.

An owner register decides who may start a new exchange. A side may only claim it while it is free. The host claims by writing its code and then reading the register back. A reply word (ACK or NAK) may be rung in without a claim, because the controller still holds the mailbox while it waits for that reply. When the controller's last outbound word was the no-reply command, the host may hand the mailbox back to free by itself. Both sides get level interrupt outputs.

Top module: `mbx_dual_owner`

## Requirements
- R1: The owner register is at host address 0. Its codes are 0 for free, 1 for controller and 2 for host, and it reads 0 after reset. It never holds any other value.
- R2: A host write of 2 to address 0 claims the mailbox only while the owner is free. Otherwise, and for a write of any code other than 0 or 2, the owner is unchanged.
- R3: A `ctl_claim` pulse takes a free mailbox for the controller. If it meets a host claim in the same cycle, the controller wins and the owner reads 1. A `ctl_release` pulse sets the owner to free from any state.
- R4: A host write of 0 to address 0 frees the mailbox in two cases: when the host owns it, or when the controller owns it and the controller's latest posted word had command type 0x06 (no reply). In every other case the write is ignored.
- R5: A message word has its command type in bits 31:24 and its payload in bits 23:0. Type 0x80 is ACK and type 0x81 is NAK.
- R6: The doorbell is a host write to address 3 with bit 31 (interrupt enable) and bit 27 (to controller) both set. It delivers the inbound word at address 1 to `ctl_inbox` and raises `ctl_irq`, but only when the host owns the mailbox or the inbound type is ACK or NAK. Otherwise it is refused and `ctl_irq` stays low. `ctl_consume` drops `ctl_irq`.
- R7: The command register at address 3 stores host-written bits 31:27 (31 interrupt enable, 30 host-controller destination, 29 message-pending destination, 28 power-event destination, 27 controller destination). All other bits read 0.
- R8: A `ctl_post` pulse loads `ctl_post_data` into the outbound register at address 2 and sets command bit 29. `host_msg_irq` is high while bit 29 and bit 31 are both set.
- R9: A host write to address 3 with bit 29 clear drops bit 29 and so `host_msg_irq`. If a `ctl_post` arrives in the same cycle, the post wins and bit 29 stays set.
- R10: The status register at address 4 has two bits. Bit 1 is a hang flag, set by `ctl_hang` and cleared by writing 1 to it. Bit 3 is an interrupt enable that reads back as written. `host_hang_irq` is the AND of the two. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_addr | input | 3 | Host register word address |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data for `host_addr` (combinational) |
| host_msg_irq | output | 1 | Outbound message waiting for the host |
| host_hang_irq | output | 1 | Controller hang flagged and enabled |
| ctl_claim | input | 1 | Controller claims a free mailbox |
| ctl_release | input | 1 | Controller sets the owner to free |
| ctl_post | input | 1 | Controller posts an outbound word |
| ctl_post_data | input | 32 | Outbound word to post |
| ctl_consume | input | 1 | Controller has taken the inbound word |
| ctl_hang | input | 1 | Controller reports a hang |
| ctl_irq | output | 1 | Inbound word delivered and not yet consumed |
| ctl_inbox | output | 32 | Inbound word as seen by the controller |
| mbx_owner | output | 2 | Current owner code |

## Verification
Several rules are checked by assertions on every cycle. The owner code is always legal. A host claim of a busy mailbox never changes the owner. A tie between the two claims goes to the controller. A refused doorbell never raises `ctl_irq`. A post always lands in the outbound register and sets bit 29. A write that clears bit 29 without a competing post really clears it. A hang report always latches. The bench's scenarios are what show the message-level rules. These are that reply words pass without ownership while ordinary words do not, that the host's free write depends on the type of the last posted word, and that the enable bits gate the two host interrupts as the register contents are changed step by step.

// File: rtl/mbx_pkg.sv
`timescale 1ns/1ps
package mbx_pkg;
   typedef enum logic [1:0] {
      OWN_FREE = 2'd0,
      OWN_CTL  = 2'd1,
      OWN_HOST = 2'd2
   } owner_e;

   // host register word addresses
   localparam int ADR_OWNER  = 0;
   localparam int ADR_INBOX  = 1;
   localparam int ADR_OUTBOX = 2;
   localparam int ADR_CMD    = 3;
   localparam int ADR_STATUS = 4;

   // command register bit positions (decoded by both sides)
   localparam int CMD_TO_CTL = 27;
   localparam int CMD_PWR    = 28;
   localparam int CMD_PEND   = 29;
   localparam int CMD_HC     = 30;
   localparam int CMD_IEN    = 31;

   // status register bit positions
   localparam int ST_HANG = 1;
   localparam int ST_EN   = 3;
endpackage

// File: rtl/mbx_owner_arb.sv
`timescale 1ns/1ps
module mbx_owner_arb
   import mbx_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   host_take,
   input  logic   host_free,
   input  logic   noreply_seen,
   input  logic   ctl_claim,
   input  logic   ctl_release,
   output owner_e owner
);
   owner_e owner_q, owner_d;

   always_comb begin
      owner_d = owner_q;
      if (ctl_release)
         owner_d = OWN_FREE;
      else if (ctl_claim && owner_q == OWN_FREE)
         owner_d = OWN_CTL;
      else if (host_take && owner_q == OWN_FREE)
         owner_d = OWN_HOST;
      else if (host_free &&
               (owner_q == OWN_HOST || (owner_q == OWN_CTL && noreply_seen)))
         owner_d = OWN_FREE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) owner_q <= OWN_FREE;
      else        owner_q <= owner_d;
   end

   assign owner = owner_q;

   // R1: only the three defined codes ever appear
   a_r1_owner_legal: assert property (@(posedge clk) disable iff (!rst_n)
      owner_q != 2'd3);

   // R2: host claim of a busy mailbox leaves the owner alone
   a_r2_claim_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      (host_take && owner_q != OWN_FREE && !ctl_release) |=> owner_q == $past(owner_q));

   // R3: a tie on a free mailbox goes to the controller
   a_r3_tie_ctl_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (host_take && ctl_claim && !ctl_release && owner_q == OWN_FREE) |=> owner_q == OWN_CTL);
endmodule

// File: rtl/mbx_cmd_reg.sv
`timescale 1ns/1ps
module mbx_cmd_reg
   import mbx_pkg::*;
#(
   parameter int TYPE_W = 8,
   parameter logic [TYPE_W-1:0] ACK_CODE = 'h80,
   parameter logic [TYPE_W-1:0] NAK_CODE = 'h81
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_cmd,
   input  logic [4:0]        wr_bits,    // host data bits 31:27
   input  owner_e            owner,
   input  logic [TYPE_W-1:0] inbox_type,
   input  logic              ctl_post,
   input  logic              ctl_consume,
   output logic [4:0]        cmd_bits,   // stored bits 31:27
   output logic              ctl_pend
);
   localparam int LO      = CMD_TO_CTL;
   localparam int N_BITS  = CMD_IEN - CMD_TO_CTL + 1;
   localparam int I_PEND  = CMD_PEND - LO;
   localparam int I_IEN   = CMD_IEN - LO;
   localparam int I_TOCTL = CMD_TO_CTL - LO;

   logic [N_BITS-1:0] bits_q;
   logic is_reply, ring, deliver, pend_q;

   assign is_reply = (inbox_type == ACK_CODE) || (inbox_type == NAK_CODE);
   assign ring     = wr_cmd && wr_bits[I_IEN] && wr_bits[I_TOCTL];
   assign deliver  = ring && (owner == OWN_HOST || is_reply);

   for (genvar b = 0; b < N_BITS; b++) begin : g_bit
      if (b == I_PEND) begin : g_pend
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        bits_q[b] <= 1'b0;
            else if (ctl_post) bits_q[b] <= 1'b1;
            else if (wr_cmd)   bits_q[b] <= wr_bits[b];
         end
      end else begin : g_plain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      bits_q[b] <= 1'b0;
            else if (wr_cmd) bits_q[b] <= wr_bits[b];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           pend_q <= 1'b0;
      else if (deliver)     pend_q <= 1'b1;
      else if (ctl_consume) pend_q <= 1'b0;
   end

   assign cmd_bits = bits_q;
   assign ctl_pend = pend_q;

   // R6: a refused doorbell never raises the controller interrupt
   a_r6_refused: assert property (@(posedge clk) disable iff (!rst_n)
      (ring && owner != OWN_HOST && !is_reply && !pend_q) |=> !pend_q);

   // R8: a post always leaves the pending bit set
   a_r8_post_pend: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_post |=> bits_q[I_PEND]);

   // R9: clearing write without a competing post drops the pending bit
   a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_cmd && !wr_bits[I_PEND] && !ctl_post) |=> !bits_q[I_PEND]);
endmodule

// File: rtl/mbx_status.sv
`timescale 1ns/1ps
module mbx_status (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_st,
   input  logic wr_hang,   // host data bit for the hang flag
   input  logic wr_en,     // host data bit for the enable
   input  logic ctl_hang,
   output logic hang,
   output logic en
);
   logic hang_q, en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hang_q <= 1'b0;
         en_q   <= 1'b0;
      end else begin
         if (ctl_hang)               hang_q <= 1'b1;
         else if (wr_st && wr_hang)  hang_q <= 1'b0;
         if (wr_st)                  en_q   <= wr_en;
      end
   end

   assign hang = hang_q;
   assign en   = en_q;

   // R10: a hang report always latches
   a_r10_hang_latch: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_hang |=> hang_q);
endmodule

// File: rtl/mbx_dual_owner.sv
`timescale 1ns/1ps
module mbx_dual_owner
   import mbx_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int TYPE_W = 8,
   parameter int ADDR_W = 3,
   parameter logic [TYPE_W-1:0] ACK_CODE     = 'h80,
   parameter logic [TYPE_W-1:0] NAK_CODE     = 'h81,
   parameter logic [TYPE_W-1:0] NOREPLY_CODE = 'h06
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic              host_wr,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata,
   output logic              host_msg_irq,
   output logic              host_hang_irq,
   input  logic              ctl_claim,
   input  logic              ctl_release,
   input  logic              ctl_post,
   input  logic [DATA_W-1:0] ctl_post_data,
   input  logic              ctl_consume,
   input  logic              ctl_hang,
   output logic              ctl_irq,
   output logic [DATA_W-1:0] ctl_inbox,
   output logic [1:0]        mbx_owner
);
   localparam int TYPE_LO = DATA_W - TYPE_W;
   localparam int CMD_LO  = CMD_TO_CTL;

   if (DATA_W < CMD_IEN + 1) begin : g_chk_w
      $error("DATA_W too small for the command register bits");
   end
   if (TYPE_W < 2 || TYPE_W > DATA_W - 8) begin : g_chk_t
      $error("TYPE_W out of range");
   end
   if (ADDR_W < 3) begin : g_chk_a
      $error("ADDR_W too small for the register map");
   end

   logic w_owner, w_inbox, w_cmd, w_st;
   assign w_owner = host_wr && host_addr == ADDR_W'(ADR_OWNER);
   assign w_inbox = host_wr && host_addr == ADDR_W'(ADR_INBOX);
   assign w_cmd   = host_wr && host_addr == ADDR_W'(ADR_CMD);
   assign w_st    = host_wr && host_addr == ADDR_W'(ADR_STATUS);

   logic [DATA_W-1:0] inbox_q, outbox_q;
   logic noreply_q;
   owner_e owner;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         inbox_q   <= '0;
         outbox_q  <= '0;
         noreply_q <= 1'b0;
      end else begin
         if (w_inbox) inbox_q <= host_wdata;
         if (ctl_post) begin
            outbox_q  <= ctl_post_data;
            noreply_q <= ctl_post_data[DATA_W-1 -: TYPE_W] == NOREPLY_CODE;
         end
      end
   end

   mbx_owner_arb u_own (
      .clk          (clk),
      .rst_n        (rst_n),
      .host_take    (w_owner && host_wdata == DATA_W'(OWN_HOST)),
      .host_free    (w_owner && host_wdata == DATA_W'(OWN_FREE)),
      .noreply_seen (noreply_q),
      .ctl_claim    (ctl_claim),
      .ctl_release  (ctl_release),
      .owner        (owner)
   );

   logic [4:0] cmd_bits;
   logic       pend;

   mbx_cmd_reg #(
      .TYPE_W   (TYPE_W),
      .ACK_CODE (ACK_CODE),
      .NAK_CODE (NAK_CODE)
   ) u_cmd (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_cmd      (w_cmd),
      .wr_bits     (host_wdata[CMD_IEN:CMD_LO]),
      .owner       (owner),
      .inbox_type  (inbox_q[DATA_W-1 -: TYPE_W]),
      .ctl_post    (ctl_post),
      .ctl_consume (ctl_consume),
      .cmd_bits    (cmd_bits),
      .ctl_pend    (pend)
   );

   logic hang, st_en;

   mbx_status u_st (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_st    (w_st),
      .wr_hang  (host_wdata[ST_HANG]),
      .wr_en    (host_wdata[ST_EN]),
      .ctl_hang (ctl_hang),
      .hang     (hang),
      .en       (st_en)
   );

   logic [DATA_W-1:0] cmd_word, st_word;
   always_comb begin
      cmd_word = '0;
      cmd_word[CMD_IEN:CMD_LO] = cmd_bits;
      st_word = '0;
      st_word[ST_HANG] = hang;
      st_word[ST_EN]   = st_en;
   end

   always_comb begin
      case (host_addr)
         ADDR_W'(ADR_OWNER):  host_rdata = DATA_W'(owner);
         ADDR_W'(ADR_INBOX):  host_rdata = inbox_q;
         ADDR_W'(ADR_OUTBOX): host_rdata = outbox_q;
         ADDR_W'(ADR_CMD):    host_rdata = cmd_word;
         ADDR_W'(ADR_STATUS): host_rdata = st_word;
         default:             host_rdata = '0;
      endcase
   end

   assign host_msg_irq  = cmd_bits[CMD_PEND-CMD_LO] && cmd_bits[CMD_IEN-CMD_LO];
   assign host_hang_irq = hang && st_en;
   assign ctl_irq       = pend;
   assign ctl_inbox     = inbox_q;
   assign mbx_owner     = owner;

   // R8: posted word reaches the outbound register
   a_r8_outbox: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_post |=> outbox_q == $past(ctl_post_data));

   // R5: the no-reply flag follows the type byte of the latest post
   a_r5_type_field: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_post |=> noreply_q == ($past(ctl_post_data[DATA_W-1 -: TYPE_W]) == NOREPLY_CODE));
endmodule

// File: tb/mbx_dual_owner_bench.sv
`timescale 1ns/1ps
module mbx_dual_owner_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  host_addr = '0;
   logic        host_wr = 1'b0;
   logic [31:0] host_wdata = '0;
   logic [31:0] host_rdata;
   logic        host_msg_irq, host_hang_irq;
   logic        ctl_claim = 0, ctl_release = 0, ctl_post = 0, ctl_consume = 0, ctl_hang = 0;
   logic [31:0] ctl_post_data = '0;
   logic        ctl_irq;
   logic [31:0] ctl_inbox;
   logic [1:0]  mbx_owner;

   always #2.5 clk = ~clk;

   mbx_dual_owner u_mbx_dual_owner (
      .clk(clk), .rst_n(rst_n),
      .host_addr(host_addr), .host_wr(host_wr), .host_wdata(host_wdata),
      .host_rdata(host_rdata), .host_msg_irq(host_msg_irq), .host_hang_irq(host_hang_irq),
      .ctl_claim(ctl_claim), .ctl_release(ctl_release), .ctl_post(ctl_post),
      .ctl_post_data(ctl_post_data), .ctl_consume(ctl_consume), .ctl_hang(ctl_hang),
      .ctl_irq(ctl_irq), .ctl_inbox(ctl_inbox), .mbx_owner(mbx_owner)
   );

   int checks = 0;
   int errors = 0;
   logic        chk_go = 0;
   logic [31:0] exp_q[$];
   int          sel_q[$];
   string       tag_q[$];

   // selectors for the monitor
   localparam int S_RD = 0, S_CIRQ = 1, S_MIRQ = 2, S_HIRQ = 3, S_INBOX = 4;

   // monitor: pops expected items and compares, 2 ns after the edge
   always @(posedge clk) begin
      #2;
      if (chk_go && exp_q.size() > 0) begin
         logic [31:0] e, a;
         int s;
         string t;
         e = exp_q.pop_front();
         s = sel_q.pop_front();
         t = tag_q.pop_front();
         case (s)
            S_RD:    a = host_rdata;
            S_CIRQ:  a = {31'd0, ctl_irq};
            S_MIRQ:  a = {31'd0, host_msg_irq};
            S_HIRQ:  a = {31'd0, host_hang_irq};
            default: a = ctl_inbox;
         endcase
         checks++;
         if (a !== e) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", t, a, e);
         end
      end
   end

   task automatic expect_item(input int s, input logic [2:0] adr,
                              input logic [31:0] e, input string t);
      @(negedge clk);
      host_addr = adr;
      exp_q.push_back(e);
      sel_q.push_back(s);
      tag_q.push_back(t);
      chk_go = 1;
      @(negedge clk);
      chk_go = 0;
   endtask

   task automatic hw(input logic [2:0] adr, input logic [31:0] d);
      @(negedge clk);
      host_addr = adr; host_wdata = d; host_wr = 1;
      @(negedge clk);
      host_wr = 0;
   endtask

   task automatic pulse_claim();   @(negedge clk); ctl_claim = 1;   @(negedge clk); ctl_claim = 0;   endtask
   task automatic pulse_release(); @(negedge clk); ctl_release = 1; @(negedge clk); ctl_release = 0; endtask
   task automatic pulse_consume(); @(negedge clk); ctl_consume = 1; @(negedge clk); ctl_consume = 0; endtask
   task automatic pulse_hang();    @(negedge clk); ctl_hang = 1;    @(negedge clk); ctl_hang = 0;    endtask
   task automatic post(input logic [31:0] d);
      @(negedge clk); ctl_post = 1; ctl_post_data = d;
      @(negedge clk); ctl_post = 0;
   endtask

   task automatic finish_run();
      repeat (3) @(negedge clk);
      if (exp_q.size() != 0) begin
         errors++;
         $display("FAIL queue not drained actual=%0d expected=0", exp_q.size());
      end
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      // reset state
      expect_item(S_RD, 3'd0, 32'h0, "R1 owner after reset");
      expect_item(S_RD, 3'd3, 32'h0, "R7 cmd after reset");
      expect_item(S_CIRQ, 3'd0, 32'h0, "R6 ctl_irq after reset");
      expect_item(S_MIRQ, 3'd0, 32'h0, "R8 host_msg_irq after reset");

      // host claim from free, then release by host
      hw(3'd0, 32'd1);
      expect_item(S_RD, 3'd0, 32'h0, "R2 write of controller code ignored");
      hw(3'd0, 32'd2);
      expect_item(S_RD, 3'd0, 32'h2, "R2 host claim from free");
      hw(3'd0, 32'd0);
      expect_item(S_RD, 3'd0, 32'h0, "R4 host frees own mailbox");

      // controller claim blocks host
      pulse_claim();
      expect_item(S_RD, 3'd0, 32'h1, "R3 controller claim");
      hw(3'd0, 32'd2);
      expect_item(S_RD, 3'd0, 32'h1, "R2 host claim while busy");
      hw(3'd0, 32'd0);
      expect_item(S_RD, 3'd0, 32'h1, "R4 free refused without no-reply post");
      pulse_release();
      expect_item(S_RD, 3'd0, 32'h0, "R3 controller release");

      // same-cycle tie
      @(negedge clk);
      ctl_claim = 1; host_addr = 3'd0; host_wdata = 32'd2; host_wr = 1;
      @(negedge clk);
      ctl_claim = 0; host_wr = 0;
      expect_item(S_RD, 3'd0, 32'h1, "R3 tie goes to controller");
      pulse_release();

      // refused doorbell: mailbox free, ordinary type
      hw(3'd1, 32'h0100_0042);
      hw(3'd3, 32'h8800_0000);
      expect_item(S_CIRQ, 3'd0, 32'h0, "R6 doorbell refused without ownership");

      // normal doorbell under host ownership
      hw(3'd0, 32'd2);
      hw(3'd3, 32'h8800_0000);
      expect_item(S_CIRQ, 3'd0, 32'h1, "R6 doorbell delivered");
      expect_item(S_INBOX, 3'd0, 32'h0100_0042, "R6 inbound word at controller");
      expect_item(S_RD, 3'd3, 32'h8800_0000, "R7 cmd bits stored");
      pulse_consume();
      expect_item(S_CIRQ, 3'd0, 32'h0, "R6 consume drops ctl_irq");
      pulse_release();
      expect_item(S_RD, 3'd0, 32'h0, "R3 release after host message");

      // reply (ACK) under controller ownership
      pulse_claim();
      hw(3'd1, 32'h8000_0005);
      hw(3'd3, 32'h8800_0000);
      expect_item(S_CIRQ, 3'd0, 32'h1, "R5 ACK reply delivered without claim");
      expect_item(S_RD, 3'd0, 32'h1, "R5 owner kept by controller");
      pulse_consume();
      hw(3'd1, 32'h8100_0007);
      hw(3'd3, 32'h8800_0000);
      expect_item(S_CIRQ, 3'd0, 32'h1, "R5 NAK reply delivered without claim");
      pulse_consume();

      // command register field mask
      hw(3'd3, 32'h7000_00FF);
      expect_item(S_RD, 3'd3, 32'h7000_0000, "R7 low bits read zero");
      expect_item(S_MIRQ, 3'd0, 32'h0, "R8 no irq without enable");
      hw(3'd3, 32'h8000_0000);

      // no-reply post, then host frees the mailbox
      post(32'h0600_1234);
      expect_item(S_MIRQ, 3'd0, 32'h1, "R8 host_msg_irq after post");
      expect_item(S_RD, 3'd2, 32'h0600_1234, "R8 outbound word");
      expect_item(S_RD, 3'd3, 32'hA000_0000, "R8 pending bit set");
      hw(3'd0, 32'd0);
      expect_item(S_RD, 3'd0, 32'h0, "R4 free after no-reply post");
      hw(3'd3, 32'h8000_0000);
      expect_item(S_MIRQ, 3'd0, 32'h0, "R9 host clears pending bit");

      // clearing write and post in the same cycle
      @(negedge clk);
      host_addr = 3'd3; host_wdata = 32'h8000_0000; host_wr = 1;
      ctl_post = 1; ctl_post_data = 32'h0300_0000;
      @(negedge clk);
      host_wr = 0; ctl_post = 0;
      expect_item(S_MIRQ, 3'd0, 32'h1, "R9 post wins over clear");
      hw(3'd3, 32'h8000_0000);
      expect_item(S_MIRQ, 3'd0, 32'h0, "R9 later clear");

      // post with enable off, then host free refused
      hw(3'd3, 32'h0);
      post(32'h0200_0001);
      expect_item(S_MIRQ, 3'd0, 32'h0, "R8 irq gated by enable");
      expect_item(S_RD, 3'd3, 32'h2000_0000, "R8 pending without enable");
      pulse_claim();
      hw(3'd0, 32'd0);
      expect_item(S_RD, 3'd0, 32'h1, "R4 free refused after ordinary post");
      pulse_release();

      // status register
      pulse_hang();
      expect_item(S_RD, 3'd4, 32'h2, "R10 hang latched");
      expect_item(S_HIRQ, 3'd0, 32'h0, "R10 hang irq needs enable");
      hw(3'd4, 32'h8);
      expect_item(S_RD, 3'd4, 32'hA, "R10 enable set, hang kept");
      expect_item(S_HIRQ, 3'd0, 32'h1, "R10 hang irq raised");
      hw(3'd4, 32'hA);
      expect_item(S_RD, 3'd4, 32'h8, "R10 write-one clears hang");
      expect_item(S_HIRQ, 3'd0, 32'h0, "R10 hang irq dropped");
      expect_item(S_RD, 3'd5, 32'h0, "R10 unmapped address reads zero");

      finish_run();
   end
endmodule